// File: doc/BRIEF.md
# Coin-Accumulating Vend Controller

This controller sits behind a single coin slot. It adds up nickels (5 cents) and dimes (10 cents) and drives a release line once the deposit reaches 15 cents or more. Each coin sensor input is a one-cycle pulse. The controller is a four-state Moore machine, and its credit states have a fixed binary code. Any overpayment is absorbed: a dime taken at 10 cents still lands in the 15-cent state, and no change is returned. The release line stays high until a synchronous reset clears the credit.

The states are:
- `ST_0C` (code 00): no credit.
- `ST_5C` (code 01): 5 cents.
- `ST_10C` (code 10): 10 cents.
- `ST_15C` (code 11): paid.

The transitions are:
- **idle-hold**: no coin, so the state is kept.
- **nickel-step**: 0→5, 5→10, 10→15.
- **dime-step**: 0→10, 5→15, 10→15.
- **paid-hold**: 15 cents stays at 15 cents under any input.
- **clash-hold**: both coin pulses in one cycle, so the state is kept.
- **reset-clear**: any state goes to 0 cents.

A parameter chooses how the next state is built. It is either taken from the minimised flip-flop equations or from an enumerated case table. Both forms give the same behaviour.

Top module: `vend_ctrl`

## Requirements
- R1: A high `rst` at a clock edge puts the machine in `ST_0C` (code 00), so `release_o` is low after that edge. This holds whatever the coin inputs are, because reset has priority.
- R2: In a cycle with both coin inputs low, the state is unchanged.
- R3: A nickel-only cycle moves 0→5→10→15 cents.
- R4: A dime-only cycle moves 0→10 cents, and both 5 and 10 cents go to 15 cents. Excess credit is kept and never refunded.
- R5: `release_o` is high exactly when the state is `ST_15C` (code 11). It depends only on the state, so it rises in the cycle after the edge that sampled the completing coin.
- R6: Once in `ST_15C`, the machine stays there for every coin input until reset.
- R7: A cycle with both `coin_nickel` and `coin_dime` high leaves the state unchanged.
- R8: A coin input held high for k consecutive cycles counts as k separate coins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| coin_nickel | input | 1 | Nickel sensor pulse, worth 5 cents per high cycle |
| coin_dime | input | 1 | Dime sensor pulse, worth 10 cents per high cycle |
| release_o | output | 1 | Dispense release; high while 15 cents or more is held |

## Verification
The state register samples a coin at one rising edge. `release_o` is decoded from that register alone, so it shows the result within that same cycle. Every result is therefore due one edge after its stimulus. The bench drives inputs on the falling edge and checks `release_o` 1 ns after the next rising edge, against a running total that saturates at 15 cents. The bench sweeps all 256 four-cycle sequences drawn from {none, nickel, dime, both}, with a reset before each sequence. Directed runs then check reset against coins and reset from the paid state.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int CREDIT_W = 2;

    typedef enum logic [CREDIT_W-1:0] {
        ST_0C  = 2'b00,
        ST_5C  = 2'b01,
        ST_10C = 2'b10,
        ST_15C = 2'b11
    } credit_e;
endpackage

// File: rtl/vend_next.sv
module vend_next
    import vend_pkg::*;
#(
    parameter bit EQN_FORM = 1'b1
) (
    input  credit_e cur_i,
    input  logic    nickel_i,
    input  logic    dime_i,
    output credit_e nxt_o
);
    // A clash of both pulses is reduced to "no coin" before either form sees it (R7).
    logic n_q;
    logic d_q;
    assign n_q = nickel_i & ~dime_i;
    assign d_q = dime_i & ~nickel_i;

    generate
        if (EQN_FORM) begin : g_eqn
            logic q1;
            logic q0;
            logic d1;
            logic d0;
            assign q1 = cur_i[1];
            assign q0 = cur_i[0];
            assign d1 = q1 | d_q | (q0 & n_q);
            assign d0 = (n_q & ~q0) | (q0 & ~n_q) | (q1 & n_q) | (q1 & d_q);
            assign nxt_o = credit_e'({d1, d0});
        end else begin : g_case
            always_comb begin
                nxt_o = cur_i;
                unique case (cur_i)
                    ST_0C:  if (n_q) nxt_o = ST_5C;  else if (d_q) nxt_o = ST_10C;
                    ST_5C:  if (n_q) nxt_o = ST_10C; else if (d_q) nxt_o = ST_15C;
                    ST_10C: if (n_q | d_q) nxt_o = ST_15C;
                    ST_15C: nxt_o = ST_15C;
                    default: nxt_o = ST_0C;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/vend_release.sv
module vend_release
    import vend_pkg::*;
(
    input  credit_e st_i,
    output logic    release_o
);
    always_comb begin
        release_o = 1'b0;
        unique case (st_i)
            ST_0C, ST_5C, ST_10C: release_o = 1'b0;
            ST_15C:               release_o = 1'b1;
            default:              release_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter bit EQN_FORM = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic coin_nickel,
    input  logic coin_dime,
    output logic release_o
);
    credit_e state_q;
    credit_e state_d;

    vend_next #(.EQN_FORM(EQN_FORM)) u_next (
        .cur_i    (state_q),
        .nickel_i (coin_nickel),
        .dime_i   (coin_dime),
        .nxt_o    (state_d)
    );

    vend_release u_rel (
        .st_i      (state_q),
        .release_o (release_o)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_0C;
        else     state_q <= state_d;
    end

    // ---------------- assertions ----------------
    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1: the edge after a sampled reset shows zero credit and a closed release.
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (state_q == ST_0C && !release_o);
        end
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!coin_nickel && !coin_dime) |=> $stable(state_q));

    p_nickel_step_r3: assert property (@(posedge clk) disable iff (rst)
        (coin_nickel && !coin_dime && state_q != ST_15C)
        |=> (state_q == credit_e'($past(state_q) + 2'd1)));

    p_dime_step_r4: assert property (@(posedge clk) disable iff (rst)
        (coin_dime && !coin_nickel)
        |=> (state_q == (($past(state_q) == ST_0C) ? ST_10C : ST_15C)));

    p_release_after_coin_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(release_o) |-> $past(coin_nickel || coin_dime));

    p_paid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_15C) |=> (state_q == ST_15C && release_o));

    p_clash_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (coin_nickel && coin_dime) |=> $stable(state_q));
endmodule

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_nickel = 1'b0;
    logic coin_dime = 1'b0;
    logic release_o;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl u0 (
        .clk         (clk),
        .rst         (rst),
        .coin_nickel (coin_nickel),
        .coin_dime   (coin_dime),
        .release_o   (release_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s release_o=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive on the falling edge, update the model, sample 1 ns after the rising edge.
    task automatic step(input logic r, input logic n, input logic d, input string tag);
        @(negedge clk);
        rst = r; coin_nickel = n; coin_dime = d;
        if (r) model = 0;
        else if (n && !d) model = (model + 5 > 15) ? 15 : model + 5;
        else if (d && !n) model = (model + 10 > 15) ? 15 : model + 10;
        @(posedge clk);
        #1;
        check(tag, release_o, model >= 15);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, 1'b0, "R1");

        // Exhaustive sweep over all four-cycle sequences (bit0 = nickel, bit1 = dime).
        for (int seq = 0; seq < 256; seq++) begin
            step(1'b1, 1'b0, 1'b0, "R1");
            for (int k = 0; k < 4; k++) begin
                logic [1:0] sym;
                string tag;
                sym = 2'((seq >> (2 * k)) & 3);
                if (model >= 15)      tag = "R6";
                else if (sym == 2'b00) tag = "R2";
                else if (sym == 2'b01) tag = "R3";
                else if (sym == 2'b10) tag = "R4";
                else                   tag = "R7";
                step(1'b0, sym[0], sym[1], tag);
            end
        end

        // R8: a nickel held high for three cycles counts as three coins.
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b0, 1'b0, "R5");

        // R1: reset beats a dime at 10 cents; credit restarts from zero.
        step(1'b1, 1'b0, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b1, 1'b0, "R5");

        // R6 then R1: the paid state holds until reset releases it.
        step(1'b0, 1'b1, 1'b1, "R6");
        step(1'b0, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b0, "R2");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired expected=finish at %0t", $time);
            summary();
            $finish;
        end
    end
endmodule